// File: doc/BRIEF.md
# Submission/Completion Ring Pair Engine

This block is the device side of a single command queue pair. Both rings live in host memory. The host places commands in a submission ring. It then announces them only by writing the new submission tail into a doorbell. The engine keeps its own submission head. Whenever that head differs from the doorbell tail, it reads the next command through a simple memory read port and passes the command to an execution stub.

When the stub reports a status, the engine writes a completion entry into the completion ring at its own completion tail. The completion ring is bounded by the completion head, which the host writes back through a second doorbell. Interrupts go out on the vector assigned to this queue pair. They pass through a coalescing stage that waits for either a count of completions or a timeout, whichever is reached first.

Configuration inputs (depth, ring base addresses, coalescing count and wait) are assumed to stay static outside reset. The depth must lie between 2 and 65536. Addresses are in entry units: one memory word holds one ring entry.

Top module: `qp_engine`

## Requirements
- R1: After reset, the outputs `mrd_req`, `mwr_req`, `ex_req`, `irq` and `db_err` are all low. Both device pointers and both doorbell values start at zero.
- R2: A doorbell write with `db_sel`=0 sets the submission tail. The engine then reads every slot from its head up to but not including that tail, in ring order, at address `cfg_sq_base`+slot. It holds each read request and its address until `mrd_ack`.
- R3: A fetched command word carries the operation at bit 0 (1 = write, 0 = read) and the command identifier at bits 16:1. It carries the block number at bits 48:17, the host data address at bits 80:49 and the length at bits 96:81. Each field is presented unchanged on the matching `ex_*` output while `ex_req` is high.
- R4: Each completion entry is written at `cfg_cq_base`+completion tail. It holds the command identifier at bits 15:0 and the submission head after that command's fetch at bits 31:16. It holds the stub status at bits 39:32 and the phase at bit 40.
- R5: The phase bit is 1 for the first pass through the completion ring. It inverts after each write to the last slot.
- R6: Both the submission head and the completion tail step modulo `cfg_depth`, returning to slot 0 after slot `cfg_depth`-1.
- R7: No completion is written while the slot after the completion tail equals the host completion head. Posting resumes once a completion-head doorbell (`db_sel`=1) frees a slot.
- R8: A doorbell write whose value is at least `cfg_depth` leaves both doorbell values unchanged and sets `db_err`. `db_err` then stays high until reset.
- R9: With a count threshold N, `irq` is a one-cycle pulse in the cycle after the N-th held completion is recorded. A threshold of 0 or 1 signals every completion. `irq_vec` always carries the queue's vector parameter.
- R10: When the count threshold is not reached, `irq` pulses `cfg_coal_time` cycles after the cycle following the recording of the first held completion.
- R11: When the count threshold and the wait timer are reached in the same cycle, a single pulse is produced and both the held count and the timer restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | 17 | Ring depth in entries (2..65536) |
| cfg_sq_base | input | 32 | Submission ring base address |
| cfg_cq_base | input | 32 | Completion ring base address |
| cfg_coal_thresh | input | 8 | Completions per interrupt |
| cfg_coal_time | input | 16 | Coalescing wait in cycles |
| db_valid | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | 0 = submission tail, 1 = completion head |
| db_value | input | 16 | Doorbell value |
| mrd_req | output | 1 | Command read request |
| mrd_addr | output | 32 | Command read address |
| mrd_ack | input | 1 | Read data valid |
| mrd_data | input | 97 | Command word |
| ex_req | output | 1 | Command presented to stub |
| ex_op | output | 1 | Operation, 1 = write |
| ex_cid | output | 16 | Command identifier |
| ex_lba | output | 32 | Device block number |
| ex_haddr | output | 32 | Host data address |
| ex_len | output | 16 | Transfer length |
| ex_done | input | 1 | Stub finished |
| ex_status | input | 8 | Stub status code |
| mwr_req | output | 1 | Completion write request |
| mwr_addr | output | 32 | Completion write address |
| mwr_data | output | 41 | Completion entry |
| mwr_ack | input | 1 | Completion write accepted |
| irq | output | 1 | Interrupt pulse |
| irq_vec | output | 5 | Interrupt vector of this queue |
| db_err | output | 1 | Sticky bad-doorbell flag |

## Verification
The coalescing count threshold and the wait timer can be reached in the same cycle. When that happens, exactly one interrupt must result and the coalescer state must restart. The test first measures the spacing between two back-to-back completions. It then sets the wait equal to that spacing with a count threshold of two, so both conditions meet on the second completion. The check passes if a single pulse appears one cycle after that completion. A third completion must then wait the full timeout, which shows the held count was cleared rather than left to trigger early.

// File: rtl/qp_pkg.sv
// Shared widths, command/completion layouts and sequencer states.
package qp_pkg;
    parameter int PTR_W   = 16;
    parameter int DEPTH_W = PTR_W + 1;
    parameter int ADDR_W  = 32;
    parameter int LBA_W   = 32;
    parameter int LEN_W   = 16;
    parameter int CID_W   = 16;
    parameter int STS_W   = 8;
    parameter int CNT_W   = 8;
    parameter int TMR_W   = 16;
    parameter int VEC_W   = 5;

    // Command word: op at bit 0, then cid, block, host address, length.
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] haddr;
        logic [LBA_W-1:0]  lba;
        logic [CID_W-1:0]  cid;
        logic              op;
    } sq_cmd_t;

    // Completion word: cid, submission head, status, phase.
    typedef struct packed {
        logic              phase;
        logic [STS_W-1:0]  status;
        logic [PTR_W-1:0]  sqhd;
        logic [CID_W-1:0]  cid;
    } cq_entry_t;

    localparam int CMD_W = $bits(sq_cmd_t);
    localparam int CPL_W = $bits(cq_entry_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_POST
    } seq_state_t;
endpackage

// File: rtl/qp_ring_ptr.sv
// Device-owned ring pointer that steps modulo the configured depth.
// Assumes cfg_depth >= 2 and static outside reset.
module qp_ring_ptr
    import qp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic               adv,
    output logic [PTR_W-1:0]   ptr,
    output logic [PTR_W-1:0]   ptr_nxt
);
    logic [DEPTH_W-1:0] sum;

    // Successor slot with wrap at the configured depth.
    always_comb begin
        sum     = {1'b0, ptr} + DEPTH_W'(1);
        ptr_nxt = (sum >= cfg_depth) ? '0 : sum[PTR_W-1:0];
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr_nxt;
    end
endmodule

// File: rtl/qp_doorbell.sv
// Captures host doorbell writes: slot 0 holds the submission tail, slot 1
// the completion head. Out-of-range values are dropped and flagged stickily.
module qp_doorbell
    import qp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic               db_valid,
    input  logic               db_sel,
    input  logic [PTR_W-1:0]   db_value,
    output logic [PTR_W-1:0]   sq_tail,
    output logic [PTR_W-1:0]   cq_head,
    output logic               db_err
);
    localparam int N_DB = 2;

    logic in_range;
    assign in_range = ({1'b0, db_value} < cfg_depth);

    for (genvar g = 0; g < N_DB; g++) begin : g_db
        logic [PTR_W-1:0] val_q;
        // Doorbell register g: updated only by an in-range write to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (db_valid && (db_sel == 1'(g)) && in_range)
                val_q <= db_value;
        end
    end

    assign sq_tail = g_db[0].val_q;
    assign cq_head = g_db[1].val_q;

    // Sticky error on any out-of-range doorbell write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      db_err <= 1'b0;
        else if (db_valid && !in_range)  db_err <= 1'b1;
    end
endmodule

// File: rtl/qp_cmd_seq.sv
// Per-command sequencer: fetch one submission entry, hand it to the stub,
// wait for status, then post a completion when the completion ring has room.
// Handles one command at a time; memory ports hold request until acknowledge.
module qp_cmd_seq
    import qp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_sq_base,
    input  logic [ADDR_W-1:0] cfg_cq_base,
    input  logic [PTR_W-1:0]  sq_tail,
    input  logic [PTR_W-1:0]  cq_head,
    input  logic [PTR_W-1:0]  sq_head,
    input  logic [PTR_W-1:0]  sq_head_nxt,
    input  logic [PTR_W-1:0]  cq_tail,
    input  logic [PTR_W-1:0]  cq_tail_nxt,
    output logic              sq_adv,
    output logic              cq_adv,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [CMD_W-1:0]  mrd_data,
    output logic              ex_req,
    output logic              ex_op,
    output logic [CID_W-1:0]  ex_cid,
    output logic [LBA_W-1:0]  ex_lba,
    output logic [ADDR_W-1:0] ex_haddr,
    output logic [LEN_W-1:0]  ex_len,
    input  logic              ex_done,
    input  logic [STS_W-1:0]  ex_status,
    output logic              mwr_req,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [CPL_W-1:0]  mwr_data,
    input  logic              mwr_ack,
    output logic              cpl_event
);
    seq_state_t       state_q;
    sq_cmd_t          cmd_q;
    logic [PTR_W-1:0] sqhd_q;
    logic [STS_W-1:0] status_q;
    logic             phase_q;
    logic             sq_empty;
    logic             cq_full;
    cq_entry_t        entry;

    // Ring occupancy as seen from the device side.
    assign sq_empty = (sq_head == sq_tail);
    assign cq_full  = (cq_tail_nxt == cq_head);

    // Port drive and pointer advance strobes.
    always_comb begin
        mrd_req  = (state_q == ST_FETCH);
        mrd_addr = cfg_sq_base + ADDR_W'(sq_head);
        ex_req   = (state_q == ST_EXEC);
        ex_op    = cmd_q.op;
        ex_cid   = cmd_q.cid;
        ex_lba   = cmd_q.lba;
        ex_haddr = cmd_q.haddr;
        ex_len   = cmd_q.len;
        entry.phase  = phase_q;
        entry.status = status_q;
        entry.sqhd   = sqhd_q;
        entry.cid    = cmd_q.cid;
        mwr_req   = (state_q == ST_POST) && !cq_full;
        mwr_addr  = cfg_cq_base + ADDR_W'(cq_tail);
        mwr_data  = entry;
        sq_adv    = mrd_req && mrd_ack;
        cq_adv    = mwr_req && mwr_ack;
        cpl_event = cq_adv;
    end

    // State machine: idle -> fetch -> execute -> post -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (!sq_empty) state_q <= ST_FETCH;
                ST_FETCH: if (mrd_ack)   state_q <= ST_EXEC;
                ST_EXEC:  if (ex_done)   state_q <= ST_POST;
                ST_POST:  if (cq_adv)    state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Command, head snapshot and status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            sqhd_q   <= '0;
            status_q <= '0;
        end else begin
            if (sq_adv) begin
                cmd_q  <= sq_cmd_t'(mrd_data);
                sqhd_q <= sq_head_nxt;
            end
            if (ex_req && ex_done) status_q <= ex_status;
        end
    end

    // Phase inverts each time the completion tail wraps to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                              phase_q <= 1'b1;
        else if (cq_adv && (cq_tail_nxt == '0))  phase_q <= ~phase_q;
    end
endmodule

// File: rtl/qp_irq_coalesce.sv
// Interrupt coalescer: fires a one-cycle pulse when the held completion
// count reaches the threshold or the wait since the first held completion
// expires, whichever is first; both restart after a pulse.
module qp_irq_coalesce
    import qp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [TMR_W-1:0] cfg_time,
    input  logic             cpl_event,
    output logic             irq
);
    logic [CNT_W-1:0] pend_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W:0]   pend_inc;
    logic [TMR_W:0]   tmr_inc;
    logic             cnt_hit;
    logic             tmr_hit;
    logic             fire;

    // Threshold and timeout conditions.
    always_comb begin
        pend_inc = {1'b0, pend_q} + (CNT_W+1)'(1);
        tmr_inc  = {1'b0, tmr_q} + (TMR_W+1)'(1);
        cnt_hit  = cpl_event && (pend_inc >= {1'b0, cfg_thresh});
        tmr_hit  = (pend_q != '0) && (tmr_inc >= {1'b0, cfg_time});
        fire     = cnt_hit || tmr_hit;
    end

    // Held count, wait timer and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tmr_q  <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= fire;
            if (fire) begin
                pend_q <= '0;
                tmr_q  <= '0;
            end else begin
                if (cpl_event)       pend_q <= pend_inc[CNT_W-1:0];
                if (pend_q != '0)    tmr_q  <= tmr_inc[TMR_W-1:0];
                else                 tmr_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/qp_engine.sv
// Queue pair engine top: doorbell capture, device ring pointers, command
// sequencer and interrupt coalescer for one submission/completion pair.
// Assumes configuration inputs are static outside reset.
module qp_engine
    import qp_pkg::*;
#(
    parameter logic [VEC_W-1:0] IRQ_VECTOR = 5'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic [ADDR_W-1:0]  cfg_sq_base,
    input  logic [ADDR_W-1:0]  cfg_cq_base,
    input  logic [CNT_W-1:0]   cfg_coal_thresh,
    input  logic [TMR_W-1:0]   cfg_coal_time,
    input  logic               db_valid,
    input  logic               db_sel,
    input  logic [PTR_W-1:0]   db_value,
    output logic               mrd_req,
    output logic [ADDR_W-1:0]  mrd_addr,
    input  logic               mrd_ack,
    input  logic [CMD_W-1:0]   mrd_data,
    output logic               ex_req,
    output logic               ex_op,
    output logic [CID_W-1:0]   ex_cid,
    output logic [LBA_W-1:0]   ex_lba,
    output logic [ADDR_W-1:0]  ex_haddr,
    output logic [LEN_W-1:0]   ex_len,
    input  logic               ex_done,
    input  logic [STS_W-1:0]   ex_status,
    output logic               mwr_req,
    output logic [ADDR_W-1:0]  mwr_addr,
    output logic [CPL_W-1:0]   mwr_data,
    input  logic               mwr_ack,
    output logic               irq,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               db_err
);
    logic [PTR_W-1:0] sq_tail, cq_head;
    logic [PTR_W-1:0] sq_head, sq_head_nxt;
    logic [PTR_W-1:0] cq_tail, cq_tail_nxt;
    logic             sq_adv, cq_adv, cpl_event;

    assign irq_vec = IRQ_VECTOR;

    qp_doorbell u_db (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .db_valid(db_valid), .db_sel(db_sel), .db_value(db_value),
        .sq_tail(sq_tail), .cq_head(cq_head), .db_err(db_err)
    );

    qp_ring_ptr u_sq_ptr (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .adv(sq_adv),
        .ptr(sq_head), .ptr_nxt(sq_head_nxt)
    );

    qp_ring_ptr u_cq_ptr (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .adv(cq_adv),
        .ptr(cq_tail), .ptr_nxt(cq_tail_nxt)
    );

    qp_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_sq_base(cfg_sq_base), .cfg_cq_base(cfg_cq_base),
        .sq_tail(sq_tail), .cq_head(cq_head),
        .sq_head(sq_head), .sq_head_nxt(sq_head_nxt),
        .cq_tail(cq_tail), .cq_tail_nxt(cq_tail_nxt),
        .sq_adv(sq_adv), .cq_adv(cq_adv),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .ex_req(ex_req), .ex_op(ex_op), .ex_cid(ex_cid), .ex_lba(ex_lba),
        .ex_haddr(ex_haddr), .ex_len(ex_len), .ex_done(ex_done), .ex_status(ex_status),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
        .cpl_event(cpl_event)
    );

    qp_irq_coalesce u_coal (
        .clk(clk), .rst_n(rst_n),
        .cfg_thresh(cfg_coal_thresh), .cfg_time(cfg_coal_time),
        .cpl_event(cpl_event), .irq(irq)
    );
endmodule

// File: rtl/qp_engine_chk.sv
// Protocol checker for qp_engine, attached by bind.
module qp_engine_chk
    import qp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [DEPTH_W-1:0] cfg_depth,
    input logic               db_valid,
    input logic [PTR_W-1:0]   db_value,
    input logic               db_err,
    input logic               mrd_req,
    input logic               mrd_ack,
    input logic [ADDR_W-1:0]  mrd_addr,
    input logic               mwr_req,
    input logic [PTR_W-1:0]   sq_head,
    input logic [PTR_W-1:0]   sq_tail,
    input logic [PTR_W-1:0]   cq_tail_nxt,
    input logic [PTR_W-1:0]   cq_head
);
    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));

    assert_fetch_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_req |-> (sq_head != sq_tail));

    assert_head_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sq_head} < cfg_depth));

    assert_no_post_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req |-> (cq_tail_nxt != cq_head));

    assert_bad_doorbell_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (db_valid && ({1'b0, db_value} >= cfg_depth)) |=> db_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        db_err |=> db_err);
endmodule

bind qp_engine qp_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
    .db_valid(db_valid), .db_value(db_value), .db_err(db_err),
    .mrd_req(mrd_req), .mrd_ack(mrd_ack), .mrd_addr(mrd_addr),
    .mwr_req(mwr_req), .sq_head(sq_head), .sq_tail(sq_tail),
    .cq_tail_nxt(cq_tail_nxt), .cq_head(cq_head)
);

// File: tb/qp_engine_tb.sv
// Directed bench: host memory, execution stub and write sink respond at the
// falling edge; each scenario task resets, drives doorbells and checks.
module qp_engine_tb;
    import qp_pkg::*;

    localparam logic [ADDR_W-1:0] SQB = 32'h100;
    localparam logic [ADDR_W-1:0] CQB = 32'h200;
    localparam logic [VEC_W-1:0]  VEC = 5'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DEPTH_W-1:0] cfg_depth = 17'd8;
    logic [ADDR_W-1:0]  cfg_sq_base = SQB, cfg_cq_base = CQB;
    logic [CNT_W-1:0]   cfg_coal_thresh = 8'd1;
    logic [TMR_W-1:0]   cfg_coal_time = 16'd100;
    logic db_valid = 1'b0, db_sel = 1'b0;
    logic [PTR_W-1:0] db_value = '0;
    logic mrd_req, mrd_ack = 1'b0;
    logic [ADDR_W-1:0] mrd_addr;
    logic [CMD_W-1:0] mrd_data = '0;
    logic ex_req, ex_op, ex_done = 1'b0;
    logic [CID_W-1:0] ex_cid;
    logic [LBA_W-1:0] ex_lba;
    logic [ADDR_W-1:0] ex_haddr;
    logic [LEN_W-1:0] ex_len;
    logic [STS_W-1:0] ex_status = '0;
    logic mwr_req, mwr_ack = 1'b0;
    logic [ADDR_W-1:0] mwr_addr;
    logic [CPL_W-1:0] mwr_data;
    logic irq, db_err;
    logic [VEC_W-1:0] irq_vec;

    qp_engine #(.IRQ_VECTOR(VEC)) u_dut (.*);

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    sq_cmd_t   sq_mem [64];
    int        fetch_cnt, ex_cnt, cpl_cnt, irq_cnt;
    logic [ADDR_W-1:0] fetch_addr [32];
    logic [ADDR_W-1:0] cpl_addr [32];
    cq_entry_t cpl_ent [32];
    int        cpl_ack [32];
    int        irq_at [8];
    sq_cmd_t   ex_last;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    // Host memory, execution stub, completion sink and interrupt monitor.
    task automatic responders();
        forever begin
            @(negedge clk);
            if (mrd_req && !mrd_ack) begin
                mrd_ack = 1'b1;
                mrd_data = sq_mem[mrd_addr[5:0]];
                if (fetch_cnt < 32) fetch_addr[fetch_cnt] = mrd_addr;
                fetch_cnt++;
            end else mrd_ack = 1'b0;
            if (ex_req && !ex_done) begin
                ex_done = 1'b1;
                ex_status = ex_cid[7:0] ^ 8'hA5;
                ex_last = '{len: ex_len, haddr: ex_haddr, lba: ex_lba, cid: ex_cid, op: ex_op};
                ex_cnt++;
            end else ex_done = 1'b0;
            if (mwr_req && !mwr_ack) begin
                mwr_ack = 1'b1;
                if (cpl_cnt < 32) begin
                    cpl_addr[cpl_cnt] = mwr_addr;
                    cpl_ent[cpl_cnt]  = cq_entry_t'(mwr_data);
                    cpl_ack[cpl_cnt]  = cyc;
                end
                cpl_cnt++;
            end else mwr_ack = 1'b0;
            if (irq) begin
                if (irq_cnt < 8) irq_at[irq_cnt] = cyc;
                irq_cnt++;
            end
        end
    endtask

    task automatic do_reset(input int depth, input int thr, input int tmo);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_depth = DEPTH_W'(depth);
        cfg_coal_thresh = CNT_W'(thr);
        cfg_coal_time = TMR_W'(tmo);
        repeat (3) @(negedge clk);
        fetch_cnt = 0; ex_cnt = 0; cpl_cnt = 0; irq_cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ring(input logic sel, input int val);
        @(negedge clk);
        db_valid = 1'b1; db_sel = sel; db_value = PTR_W'(val);
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic load(input int slot, input int cid);
        sq_mem[slot] = '{len: LEN_W'(cid * 8), haddr: 32'hA000_0000 + 32'(cid),
                         lba: 32'h0001_0000 + 32'(cid), cid: CID_W'(cid), op: cid[0]};
    endtask

    task automatic wait_cpl(input int n, input string req);
        int k = 0;
        while (cpl_cnt < n && k < 3000) begin @(negedge clk); k++; end
        check(cpl_cnt >= n, req, "completion count reached", 64'(cpl_cnt), 64'(n));
    endtask

    task automatic t_reset();
        do_reset(8, 1, 100);
        check(!mrd_req && !mwr_req && !ex_req, "R1", "no requests after reset",
              {61'd0, mrd_req, mwr_req, ex_req}, 64'd0);
        eq("R1", "irq after reset", 64'(irq), 0);
        eq("R1", "db_err after reset", 64'(db_err), 0);
    endtask

    task automatic t_single();
        sq_cmd_t c;
        do_reset(8, 1, 100);
        sq_mem[0] = '{len: 16'h40, haddr: 32'hDEAD_0000, lba: 32'h1234, cid: 16'h11, op: 1'b1};
        c = sq_mem[0];
        ring(1'b0, 1);
        wait_cpl(1, "R2");
        repeat (4) @(negedge clk);
        eq("R2", "fetch address", 64'(fetch_addr[0]), 64'(SQB));
        eq("R3", "exec op", 64'(ex_last.op), 64'(c.op));
        eq("R3", "exec cid", 64'(ex_last.cid), 64'(c.cid));
        eq("R3", "exec lba", 64'(ex_last.lba), 64'(c.lba));
        eq("R3", "exec haddr", 64'(ex_last.haddr), 64'(c.haddr));
        eq("R3", "exec len", 64'(ex_last.len), 64'(c.len));
        eq("R4", "cq address", 64'(cpl_addr[0]), 64'(CQB));
        eq("R4", "entry cid", 64'(cpl_ent[0].cid), 64'h11);
        eq("R4", "entry sq head", 64'(cpl_ent[0].sqhd), 1);
        eq("R4", "entry status", 64'(cpl_ent[0].status), 64'(8'h11 ^ 8'hA5));
        eq("R5", "first phase", 64'(cpl_ent[0].phase), 1);
        eq("R9", "irq count thresh 1", 64'(irq_cnt), 1);
        eq("R9", "irq cycle thresh 1", 64'(irq_at[0]), 64'(cpl_ack[0] + 1));
        eq("R9", "irq vector", 64'(irq_vec), 64'(VEC));
    endtask

    task automatic t_batch();
        do_reset(8, 3, 1000);
        for (int i = 0; i < 3; i++) load(i, 21 + i);
        ring(1'b0, 3);
        wait_cpl(3, "R2");
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            eq("R2", "fetch order address", 64'(fetch_addr[i]), 64'(SQB + 32'(i)));
            eq("R4", "entry cid order", 64'(cpl_ent[i].cid), 64'(21 + i));
            eq("R4", "entry sq head", 64'(cpl_ent[i].sqhd), 64'(i + 1));
        end
        eq("R9", "irq count thresh 3", 64'(irq_cnt), 1);
        eq("R9", "irq on third completion", 64'(irq_at[0]), 64'(cpl_ack[2] + 1));
    endtask

    task automatic t_timer();
        do_reset(8, 4, 20);
        load(0, 40);
        ring(1'b0, 1);
        wait_cpl(1, "R10");
        repeat (30) @(negedge clk);
        eq("R10", "irq count by timer", 64'(irq_cnt), 1);
        eq("R10", "irq timer cycle", 64'(irq_at[0]), 64'(cpl_ack[0] + 1 + 20));
    endtask

    task automatic t_wrap();
        do_reset(4, 1, 100);
        for (int i = 0; i < 4; i++) load(i, 50 + i);
        ring(1'b0, 3);
        wait_cpl(3, "R6");
        ring(1'b1, 3);
        load(0, 60);
        ring(1'b0, 1);
        wait_cpl(5, "R6");
        repeat (4) @(negedge clk);
        eq("R6", "sq wrap fetch 4", 64'(fetch_addr[3]), 64'(SQB + 3));
        eq("R6", "sq wrap fetch 5", 64'(fetch_addr[4]), 64'(SQB));
        eq("R6", "cq wrap addr 5", 64'(cpl_addr[4]), 64'(CQB));
        eq("R6", "sq head after wrap", 64'(cpl_ent[3].sqhd), 0);
        eq("R5", "phase slot 3 first pass", 64'(cpl_ent[3].phase), 1);
        eq("R5", "phase after wrap", 64'(cpl_ent[4].phase), 0);
        eq("R4", "wrapped entry cid", 64'(cpl_ent[4].cid), 60);
    endtask

    task automatic t_full();
        do_reset(4, 1, 100);
        for (int i = 0; i < 4; i++) load(i, 70 + i);
        ring(1'b0, 3);
        wait_cpl(3, "R7");
        ring(1'b0, 0);
        repeat (40) @(negedge clk);
        eq("R7", "executed while full", 64'(ex_cnt), 4);
        eq("R7", "no post while full", 64'(cpl_cnt), 3);
        eq("R7", "write request low while full", 64'(mwr_req), 0);
        ring(1'b1, 2);
        wait_cpl(4, "R7");
        eq("R7", "post after head doorbell addr", 64'(cpl_addr[3]), 64'(CQB + 3));
        eq("R7", "post after head doorbell cid", 64'(cpl_ent[3].cid), 73);
    endtask

    task automatic t_bad_db();
        do_reset(4, 1, 100);
        load(0, 80);
        ring(1'b0, 4);
        repeat (20) @(negedge clk);
        eq("R8", "out-of-range tail ignored", 64'(fetch_cnt), 0);
        eq("R8", "error flag set", 64'(db_err), 1);
        ring(1'b1, 7);
        ring(1'b0, 1);
        wait_cpl(1, "R8");
        repeat (20) @(negedge clk);
        eq("R8", "single fetch after valid tail", 64'(fetch_cnt), 1);
        eq("R8", "error flag sticky", 64'(db_err), 1);
    endtask

    task automatic t_coincide();
        int gap;
        do_reset(8, 1, 1000);
        load(0, 90); load(1, 91); load(2, 92);
        ring(1'b0, 2);
        wait_cpl(2, "R11");
        gap = cpl_ack[1] - cpl_ack[0];
        do_reset(8, 2, gap);
        ring(1'b0, 2);
        wait_cpl(2, "R11");
        repeat (gap + 4) @(negedge clk);
        eq("R11", "completion spacing repeatable", 64'(cpl_ack[1] - cpl_ack[0]), 64'(gap));
        eq("R11", "single pulse on coincidence", 64'(irq_cnt), 1);
        eq("R11", "coincident pulse cycle", 64'(irq_at[0]), 64'(cpl_ack[1] + 1));
        ring(1'b0, 3);
        wait_cpl(3, "R11");
        repeat (gap + 4) @(negedge clk);
        eq("R11", "irq count after restart", 64'(irq_cnt), 2);
        eq("R11", "count restarted, timer pulse", 64'(irq_at[1]), 64'(cpl_ack[2] + 1 + gap));
    endtask

    initial begin
        fork responders(); join_none
        t_reset();
        t_single();
        t_batch();
        t_timer();
        t_wrap();
        t_full();
        t_bad_db();
        t_coincide();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule